// File: doc/BRIEF.md
# Nth Largest Coefficient Tree

This block receives the wavelet coefficients of one spike waveform, one at a time. Each coefficient goes into a small pointer-linked binary tree as soon as it arrives. The caller picks a rank N, and the block reports the amplitude that ranks Nth from the top among the absolute values received so far. It also reports the largest amplitude. A later compression stage uses these two values: the Nth amplitude is its keep/discard threshold and the largest amplitude is its normalisation divisor.

The tree holds 48 nodes, one for each coefficient of a waveform. Every node stores:
- the coefficient magnitude;
- the number of stored magnitudes strictly larger than its own (its "above count");
- a link toward a smaller-or-equal magnitude;
- a link toward a larger magnitude.

When a coefficient is accepted, every stored node with a smaller magnitude increments its above count in the same cycle, and the new node's own count is set from a parallel comparison. The new node is then hooked into the tree by a walk from the root that moves one level per cycle. While the walk runs, the input ready signal is low. The rank lookup needs no sort: the Nth amplitude is the smallest magnitude whose above count is below N, and the maximum is any node whose above count is zero.

A start pulse opens a new waveform by invalidating every node. After the 48th coefficient has been linked, a done flag rises. The block then accepts nothing further until the next start pulse.

Top module: `nth_coef_tree`

## Requirements
- R1: After reset and after a start pulse, coef_ready_o is 1, done_o is 0, and both cn_o and cmax_o read 0.
- R2: Coefficients are two's complement and are ranked by absolute value; the most negative input value (-32768 at 16 bits) counts as magnitude 32768.
- R3: cmax_o equals the largest magnitude among the stored coefficients.
- R4: With rank_i = N, cn_o equals the Nth entry of the stored magnitudes sorted in descending order, with duplicates counted as separate entries, so rank 1 always equals cmax_o.
- R5: rank_i = 0 makes cn_o read 0; a rank larger than the number of stored coefficients makes cn_o the smallest stored magnitude.
- R6: Equal magnitudes do not count as larger than each other: a waveform of identical magnitudes gives that magnitude at every rank from 1 to 48.
- R7: The first coefficient after a clear is stored with no stall. A later coefficient holds coef_ready_o low for exactly k cycles after its acceptance, where k is the number of nodes on its search path; for a strictly rising input sequence, k equals the coefficient's position counted from 0.
- R8: done_o rises at the clock edge that links the 48th coefficient; while done_o is 1, coef_ready_o stays 0 until a start pulse.
- R9: Before done_o, cn_o and cmax_o already reflect the coefficients stored so far, and a change of rank_i shows on cn_o without any clock edge.
- R10: start_i clears all stored coefficients, aborts an insertion in progress, and takes priority over a coefficient offered in the same cycle, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start of a new waveform; clears the tree |
| coef_valid_i | input | 1 | Coefficient on coef_i is offered |
| coef_i | input | 16 | Signed wavelet coefficient |
| coef_ready_o | output | 1 | Block can take a coefficient this cycle |
| rank_i | input | 6 | Rank N of the wanted amplitude (1 = largest) |
| cn_o | output | 16 | Magnitude holding rank N |
| cmax_o | output | 16 | Largest stored magnitude |
| done_o | output | 1 | All 48 coefficients stored and linked |

## Verification
The above counts feed cn_o combinationally. A missed or extra increment therefore shows up on cn_o in the very cycle after the insertion, for the ranks close to the affected node. Sweeping the rank after each waveform exposes it no matter where the fault sits. A broken link or a wrong comparison during the walk changes how long ready stays low, so directed sequences whose path lengths are known (rising, falling, all equal) expose it through exact stall counts and the exact done latency. Clear faults leave stale magnitudes behind, and these appear on cmax_o right after a start pulse.

// File: rtl/nlt_pkg.sv
package nlt_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_STEP = 1'b1
  } walk_state_e;

endpackage

// File: rtl/nlt_node_store.sv
module nlt_node_store #(
  parameter int NODES  = 48,
  parameter int MAG_W  = 16,
  parameter int IDX_W  = $clog2(NODES),
  parameter int CNT_W  = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [MAG_W-1:0] wr_mag_i,
  input  logic             link_en_i,
  input  logic [IDX_W-1:0] link_idx_i,
  input  logic             link_right_i,
  input  logic [IDX_W-1:0] link_tgt_i,
  output logic [NODES-1:0] valid_o,
  output logic [MAG_W-1:0] mag_o  [NODES],
  output logic [CNT_W-1:0] gcnt_o [NODES],
  output logic [IDX_W-1:0] lptr_o [NODES],
  output logic [IDX_W-1:0] rptr_o [NODES],
  output logic [NODES-1:0] lvld_o,
  output logic [NODES-1:0] rvld_o
);

  // number of stored nodes strictly larger than the incoming magnitude
  logic [CNT_W-1:0] new_cnt;

  always_comb begin
    new_cnt = '0;
    for (int j = 0; j < NODES; j++) begin
      if (valid_o[j] && (mag_o[j] > wr_mag_i)) begin
        new_cnt = new_cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NODES; g++) begin : g_node
    logic             vld_q,  vld_d;
    logic [MAG_W-1:0] mag_q,  mag_d;
    logic [CNT_W-1:0] cnt_q,  cnt_d;
    logic [IDX_W-1:0] lp_q,   lp_d;
    logic [IDX_W-1:0] rp_q,   rp_d;
    logic             lv_q,   lv_d;
    logic             rv_q,   rv_d;
    logic             sel_wr, sel_link, bump;

    assign sel_wr   = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign sel_link = link_en_i && (link_idx_i == IDX_W'(g));
    assign bump     = wr_en_i && vld_q && (mag_q < wr_mag_i);

    always_comb begin
      vld_d = vld_q;
      mag_d = mag_q;
      cnt_d = cnt_q;
      lp_d  = lp_q;
      rp_d  = rp_q;
      lv_d  = lv_q;
      rv_d  = rv_q;
      if (clr_i) begin
        vld_d = 1'b0;
        lv_d  = 1'b0;
        rv_d  = 1'b0;
      end else begin
        if (sel_wr) begin
          vld_d = 1'b1;
          mag_d = wr_mag_i;
          cnt_d = new_cnt;
          lv_d  = 1'b0;
          rv_d  = 1'b0;
        end else if (bump) begin
          cnt_d = cnt_q + 1'b1;
        end
        if (sel_link) begin
          if (link_right_i) begin
            rv_d = 1'b1;
            rp_d = link_tgt_i;
          end else begin
            lv_d = 1'b1;
            lp_d = link_tgt_i;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        mag_q <= '0;
        cnt_q <= '0;
        lp_q  <= '0;
        rp_q  <= '0;
        lv_q  <= 1'b0;
        rv_q  <= 1'b0;
      end else begin
        vld_q <= vld_d;
        mag_q <= mag_d;
        cnt_q <= cnt_d;
        lp_q  <= lp_d;
        rp_q  <= rp_d;
        lv_q  <= lv_d;
        rv_q  <= rv_d;
      end
    end

    assign valid_o[g] = vld_q;
    assign mag_o[g]   = mag_q;
    assign gcnt_o[g]  = cnt_q;
    assign lptr_o[g]  = lp_q;
    assign rptr_o[g]  = rp_q;
    assign lvld_o[g]  = lv_q;
    assign rvld_o[g]  = rv_q;

    // a stored node can never see more larger nodes than the tree holds
    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (cnt_q < CNT_W'(NODES)));
  end

  // a write must land in a free slot
  assert_slot_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_i) |-> !valid_o[wr_idx_i]);

  // links only join two stored nodes
  assert_link_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en_i && !clr_i) |-> (valid_o[link_idx_i] && valid_o[link_tgt_i]));

  // a clear empties every slot
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_o == '0));

endmodule

// File: rtl/nlt_walker.sv
module nlt_walker
  import nlt_pkg::*;
#(
  parameter int NODES  = 48,
  parameter int MAG_W  = 16,
  parameter int IDX_W  = $clog2(NODES),
  parameter int CNT_W  = $clog2(NODES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    coef_valid_i,
  input  logic signed [MAG_W-1:0] coef_i,
  output logic                    ready_o,
  output logic                    done_o,
  input  logic [MAG_W-1:0]        node_mag_i [NODES],
  input  logic [IDX_W-1:0]        lptr_i     [NODES],
  input  logic [IDX_W-1:0]        rptr_i     [NODES],
  input  logic [NODES-1:0]        lvld_i,
  input  logic [NODES-1:0]        rvld_i,
  output logic                    wr_en_o,
  output logic [IDX_W-1:0]        wr_idx_o,
  output logic [MAG_W-1:0]        wr_mag_o,
  output logic                    link_en_o,
  output logic [IDX_W-1:0]        link_idx_o,
  output logic                    link_right_o,
  output logic [IDX_W-1:0]        link_tgt_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(NODES);
  localparam logic [IDX_W-1:0] ROOT = '0;

  walk_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic [IDX_W-1:0] cur_q,   cur_d;
  logic [IDX_W-1:0] nidx_q,  nidx_d;
  logic [MAG_W-1:0] nmag_q,  nmag_d;
  logic [CNT_W-1:0] steps_q, steps_d;

  logic [MAG_W-1:0] mag_in;
  logic             accept;
  logic             go_right;
  logic             child_vld;
  logic [IDX_W-1:0] child_idx;

  assign mag_in    = coef_i[MAG_W-1] ? (~coef_i + 1'b1) : coef_i;
  assign ready_o   = (state_q == WALK_IDLE) && (cnt_q < FULL);
  assign done_o    = (state_q == WALK_IDLE) && (cnt_q == FULL);
  assign accept    = ready_o && coef_valid_i && !start_i;
  assign go_right  = nmag_q > node_mag_i[cur_q];
  assign child_vld = go_right ? rvld_i[cur_q] : lvld_i[cur_q];
  assign child_idx = go_right ? rptr_i[cur_q] : lptr_i[cur_q];

  assign wr_idx_o     = cnt_q[IDX_W-1:0];
  assign wr_mag_o     = mag_in;
  assign link_idx_o   = cur_q;
  assign link_right_o = go_right;
  assign link_tgt_o   = nidx_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cur_d     = cur_q;
    nidx_d    = nidx_q;
    nmag_d    = nmag_q;
    wr_en_o   = 1'b0;
    link_en_o = 1'b0;
    if (start_i) begin
      state_d = WALK_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        WALK_IDLE: begin
          if (accept) begin
            wr_en_o = 1'b1;
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q != '0) begin
              state_d = WALK_STEP;
              cur_d   = ROOT;
              nidx_d  = cnt_q[IDX_W-1:0];
              nmag_d  = mag_in;
            end
          end
        end
        WALK_STEP: begin
          if (!child_vld) begin
            link_en_o = 1'b1;
            state_d   = WALK_IDLE;
          end else begin
            cur_d = child_idx;
          end
        end
        default: state_d = WALK_IDLE;
      endcase
    end
  end

  // walk length monitor
  always_comb begin
    steps_d = '0;
    if (state_q == WALK_STEP && !start_i) begin
      steps_d = steps_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      nidx_q  <= '0;
      nmag_q  <= '0;
      steps_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cur_q   <= cur_d;
      nidx_q  <= nidx_d;
      nmag_q  <= nmag_d;
      steps_q <= steps_d;
    end
  end

  // a walk never visits more nodes than are stored ahead of the new one
  assert_walk_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WALK_STEP) |-> (steps_q < CNT_W'(NODES - 1)));

  // the walk only ever points at a stored index
  assert_cursor_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WALK_STEP) |-> (cur_q < nidx_q));

  // once full, the stored count holds until a start
  assert_hold_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

endmodule

// File: rtl/nlt_rank_select.sv
module nlt_rank_select #(
  parameter int NODES = 48,
  parameter int MAG_W = 16,
  parameter int CNT_W = $clog2(NODES + 1)
) (
  input  logic [NODES-1:0] valid_i,
  input  logic [MAG_W-1:0] mag_i  [NODES],
  input  logic [CNT_W-1:0] gcnt_i [NODES],
  input  logic [CNT_W-1:0] rank_i,
  output logic [MAG_W-1:0] cn_o,
  output logic [MAG_W-1:0] cmax_o
);

  logic cn_hit;
  logic top_hit;

  always_comb begin
    cn_o    = '0;
    cmax_o  = '0;
    cn_hit  = 1'b0;
    top_hit = 1'b0;
    for (int j = 0; j < NODES; j++) begin
      // candidate for rank N: fewer than N magnitudes above it; keep the smallest
      if (valid_i[j] && (gcnt_i[j] < rank_i) && (!cn_hit || (mag_i[j] < cn_o))) begin
        cn_o   = mag_i[j];
        cn_hit = 1'b1;
      end
      // nothing above it: the maximum
      if (valid_i[j] && (gcnt_i[j] == '0) && !top_hit) begin
        cmax_o  = mag_i[j];
        top_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nth_coef_tree.sv
module nth_coef_tree #(
  parameter int NODES = 48,
  parameter int MAG_W = 16,
  parameter int IDX_W = $clog2(NODES),
  parameter int CNT_W = $clog2(NODES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    coef_valid_i,
  input  logic signed [MAG_W-1:0] coef_i,
  output logic                    coef_ready_o,
  input  logic [CNT_W-1:0]        rank_i,
  output logic [MAG_W-1:0]        cn_o,
  output logic [MAG_W-1:0]        cmax_o,
  output logic                    done_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [MAG_W-1:0] wr_mag;
  logic             link_en;
  logic [IDX_W-1:0] link_idx;
  logic             link_right;
  logic [IDX_W-1:0] link_tgt;
  logic [NODES-1:0] node_vld;
  logic [MAG_W-1:0] node_mag  [NODES];
  logic [CNT_W-1:0] node_gcnt [NODES];
  logic [IDX_W-1:0] node_lp   [NODES];
  logic [IDX_W-1:0] node_rp   [NODES];
  logic [NODES-1:0] node_lv;
  logic [NODES-1:0] node_rv;

  nlt_walker #(
    .NODES(NODES), .MAG_W(MAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) walker_i (
    .clk          (clk_i),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .coef_valid_i (coef_valid_i),
    .coef_i       (coef_i),
    .ready_o      (coef_ready_o),
    .done_o       (done_o),
    .node_mag_i   (node_mag),
    .lptr_i       (node_lp),
    .rptr_i       (node_rp),
    .lvld_i       (node_lv),
    .rvld_i       (node_rv),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_mag_o     (wr_mag),
    .link_en_o    (link_en),
    .link_idx_o   (link_idx),
    .link_right_o (link_right),
    .link_tgt_o   (link_tgt)
  );

  nlt_node_store #(
    .NODES(NODES), .MAG_W(MAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) store_i (
    .clk          (clk_i),
    .rst_n        (rst_n),
    .clr_i        (start_i),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_mag_i     (wr_mag),
    .link_en_i    (link_en),
    .link_idx_i   (link_idx),
    .link_right_i (link_right),
    .link_tgt_i   (link_tgt),
    .valid_o      (node_vld),
    .mag_o        (node_mag),
    .gcnt_o       (node_gcnt),
    .lptr_o       (node_lp),
    .rptr_o       (node_rp),
    .lvld_o       (node_lv),
    .rvld_o       (node_rv)
  );

  nlt_rank_select #(
    .NODES(NODES), .MAG_W(MAG_W), .CNT_W(CNT_W)
  ) select_i (
    .valid_i (node_vld),
    .mag_i   (node_mag),
    .gcnt_i  (node_gcnt),
    .rank_i  (rank_i),
    .cn_o    (cn_o),
    .cmax_o  (cmax_o)
  );

  // the selected threshold can never exceed the maximum
  assert_cmax_ge_cn_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|node_vld) |-> (cmax_o >= cn_o));

  // done means every slot holds a coefficient
  assert_full_tree_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (&node_vld));

  // an empty tree reports zero amplitudes
  assert_empty_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (node_vld == '0) |-> (cmax_o == '0 && cn_o == '0));

endmodule

// File: tb/nth_coef_tree_tb_top.sv
module nth_coef_tree_tb_top;

  localparam int NODES = 48;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic               cvalid;
  logic signed [15:0] coef;
  logic               ready;
  logic [5:0]         rank;
  logic [15:0]        cn;
  logic [15:0]        cmax;
  logic               done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int exp_mag [NODES];
  int exp_n;
  int stim    [NODES];

  always #10 clk = ~clk;

  nth_coef_tree dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .coef_valid_i (cvalid),
    .coef_i       (coef),
    .coef_ready_o (ready),
    .rank_i       (rank),
    .cn_o         (cn),
    .cmax_o       (cmax),
    .done_o       (done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_rank(input int r);
    int s [NODES];
    int t;
    for (int i = 0; i < exp_n; i++) s[i] = exp_mag[i];
    for (int i = 0; i < exp_n; i++)
      for (int j = 0; j + 1 < exp_n - i; j++)
        if (s[j] < s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    if (r == 0 || exp_n == 0) return 0;
    if (r > exp_n) return s[exp_n-1];
    return s[r-1];
  endfunction

  function automatic int mag_of(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_n = 0;
  endtask

  // returns at the negedge right after the accepting edge
  task automatic send(input int v);
    @(negedge clk);
    while (!ready) @(negedge clk);
    cvalid = 1'b1;
    coef   = 16'(v);
    @(negedge clk);
    cvalid = 1'b0;
    exp_mag[exp_n] = mag_of(v);
    exp_n++;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic check_rank(input string req, input int r);
    rank = 6'(r);
    #1;
    check(req, $sformatf("cn at rank %0d", r), int'(cn), model_rank(r));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "ready after reset", int'(ready), 1);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "cn after reset", int'(cn), 0);
    check("R1", "cmax after reset", int'(cmax), 0);
  endtask

  task automatic t_ascending();
    int k;
    pulse_start();
    for (int i = 0; i < NODES; i++) begin
      send(i * 100 + 5);
      if (i == 0) check("R7", "no stall on first", int'(ready), 1);
      if (i == 1 || i == 10 || i == 30) begin
        k = 0;
        while (!ready && k < 100) begin k++; @(negedge clk); end
        check("R7", $sformatf("stall after insert %0d", i), k, i);
      end
      if (i == 20) begin
        check("R9", "done low mid waveform", int'(done), 0);
        check("R9", "cmax mid waveform", int'(cmax), model_rank(1));
        check_rank("R9", 5);
        check_rank("R9", 3);
      end
      if (i == NODES - 1) begin
        k = 0;
        while (!done && k < 100) begin k++; @(negedge clk); end
        check("R8", "done latency of last insert", k, NODES - 1);
      end
    end
    check("R8", "ready low while done", int'(ready), 0);
    check("R3", "cmax rising input", int'(cmax), 4705);
    check_rank("R4", 1);
    check_rank("R4", 10);
    check_rank("R4", 48);
    check_rank("R5", 0);
    // offered coefficient while full must change nothing
    @(negedge clk);
    cvalid = 1'b1; coef = 16'sd30000;
    @(negedge clk);
    cvalid = 1'b0;
    check("R8", "cmax unchanged while full", int'(cmax), 4705);
    check("R8", "still done", int'(done), 1);
  endtask

  task automatic t_mixed();
    int v;
    pulse_start();
    for (int i = 0; i < NODES; i++) begin
      if (i == 5)        v = -32768;
      else if (i == 6)   v = 32767;
      else if (i % 8 == 3) v = (i % 16 == 3) ? 1200 : -1200;
      else               v = (((i * 37 + 11) % 97) - 48) * 300;
      stim[i] = v;
      send(v);
    end
    wait_done();
    check("R8", "done after mixed fill", int'(done), 1);
    check("R2", "cmax most negative", int'(cmax), 32768);
    check_rank("R2", 2);
    for (int r = 1; r <= NODES; r += 5) check_rank("R4", r);
    check_rank("R4", 48);
  endtask

  task automatic t_equal();
    pulse_start();
    for (int i = 0; i < NODES; i++) send((i % 2 == 0) ? -250 : 250);
    wait_done();
    check("R6", "cmax all equal", int'(cmax), 250);
    for (int r = 1; r <= NODES; r += 6) check_rank("R6", r);
    check_rank("R6", 48);
  endtask

  task automatic t_partial_rank();
    pulse_start();
    for (int i = 0; i < 10; i++) send(30000 - i * 600);
    @(negedge clk);
    check("R9", "done low with ten stored", int'(done), 0);
    check_rank("R5", 63);
    check_rank("R5", 11);
    check_rank("R9", 4);
    check_rank("R5", 0);
  endtask

  task automatic t_restart();
    pulse_start();
    for (int i = 0; i < 5; i++) send(1000 + i);
    send(2000);
    // still walking: abort with a start, with a coefficient offered too
    start = 1'b1; cvalid = 1'b1; coef = 16'sd12345;
    @(negedge clk);
    start = 1'b0; cvalid = 1'b0;
    exp_n = 0;
    check("R10", "cmax after abort", int'(cmax), 0);
    check("R10", "ready after abort", int'(ready), 1);
    // start with valid while idle: coefficient dropped
    start = 1'b1; cvalid = 1'b1; coef = 16'sd777;
    @(negedge clk);
    start = 1'b0; cvalid = 1'b0;
    check("R10", "cmax after start with valid", int'(cmax), 0);
    check("R1", "done after start", int'(done), 0);
    check_rank("R1", 1);
    send(-40); send(90); send(15);
    @(negedge clk);
    check("R10", "cmax new waveform only", int'(cmax), 90);
    check_rank("R10", 3);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cvalid = 1'b0; coef = '0; rank = 6'd1;
    exp_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ascending();
    t_mixed();
    t_equal();
    t_partial_rank();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule